// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block holds one atomic-access reservation for each hardware thread context. A load-linked request records the 16-byte-aligned granule of its physical address and arms that context's reservation flag. A later store-conditional from the same context is judged against the flag and the stored granule. The block then says whether the store may go on to memory, gives a result code for the destination register, and names the cause of any failure.

Uncacheable store-conditionals skip the check completely. They are always forwarded and get a result code of their own. Each context has a saturating counter of consecutive failed store-conditionals, which helps spot livelock. A one-cycle warning pulse marks every time that counter reaches a multiple of a configurable period. An external per-context invalidate mask lets coherence or exception logic clear reservations.

Requests are single-cycle strobes. The decision for a store-conditional is registered and shows up on the cycle after the request, with a valid flag.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked request for context c stores its physical address with the low GRAN_BITS bits forced to zero and sets c's reservation flag. If a store-conditional for c arrives in the same cycle, it is judged against the state held before that cycle, and the load-linked still leaves the flag set.
- R2: A cacheable store-conditional whose context has a clear flag fails. It reports code 0 (fail), is not forwarded, and raises the no-reservation cause.
- R3: A cacheable store-conditional whose context has a set flag but a different granule fails with code 0. It is not forwarded, and it raises the mismatch cause instead of the no-reservation cause. On a failure exactly one of the two causes is high; outside a failure neither is.
- R4: A failing cacheable store-conditional clears its context's reservation flag.
- R5: A passing cacheable store-conditional is forwarded with code 1. It clears its context's flag and resets that context's failure count to 0, so a second store-conditional without a new load-linked fails.
- R6: An uncacheable store-conditional is always forwarded with code 2. It raises no cause and leaves the flag, the stored granule and the failure count unchanged.
- R7: Each failed store-conditional raises its context's consecutive-failure count by one, up to a limit of 2^CNT_W-1, where it stays. The response reports the count after the update.
- R8: The warn output pulses for exactly the failure response whose count increment lands on a multiple of WARN_PERIOD. A failure at the saturated limit gives no pulse.
- R9: Bit c of the invalidate mask clears context c's flag. A load-linked for c in the same cycle wins, and the flag ends set.
- R10: Each store-conditional strobe produces exactly one response one cycle later, with rsp_valid high and the request's context echoed. rsp_valid is low in every other cycle.
- R11: Synchronous active-high reset clears all flags, stored granules and failure counts, and drops rsp_valid.
- R12: Contexts are independent. A request or invalidate for one context does not change another context's flag or count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ll_valid | input | 1 | Load-linked strobe |
| ll_ctx | input | CTX_W | Context of the load-linked |
| ll_addr | input | ADDR_W | Physical address of the load-linked |
| sc_valid | input | 1 | Store-conditional strobe |
| sc_ctx | input | CTX_W | Context of the store-conditional |
| sc_addr | input | ADDR_W | Physical address of the store-conditional |
| sc_uncached | input | 1 | Store-conditional targets uncacheable space |
| inv_mask | input | NUM_CTX | Per-context reservation clear |
| rsp_valid | output | 1 | Decision valid |
| rsp_ctx | output | CTX_W | Context of the decision |
| rsp_forward | output | 1 | Store may be sent to memory |
| rsp_code | output | 2 | 0 fail, 1 pass, 2 uncacheable bypass |
| rsp_fail_nolock | output | 1 | Failure cause: no reservation |
| rsp_fail_mismatch | output | 1 | Failure cause: granule mismatch |
| rsp_fail_count | output | CNT_W | Consecutive failures of the context after this decision |
| rsp_warn | output | 1 | Failure count reached a multiple of WARN_PERIOD |

## Verification
The bench builds the block with two contexts, 16-bit addresses, a 4-bit failure counter and a warning period of 5. With these values, warning pulses at counts 5, 10 and 15 and the saturation limit of 15 are reached within a few dozen requests, and the case of a failure at the limit with no pulse is reached as well. Two contexts are enough to show that a load-linked, an invalidate or a failure on one context leaves the other untouched. A granule compare that differs only in the top address bit, or only inside the 16-byte granule, shows that the mask covers exactly the low four bits.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [1:0] {
    SC_FAIL   = 2'd0,
    SC_PASS   = 2'd1,
    SC_BYPASS = 2'd2
  } sc_code_e;

endpackage

// File: rtl/llsc_resv_slot.sv
module llsc_resv_slot #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_i,
  input  logic [ADDR_W-1:0] set_gran_i,
  input  logic              clr_i,
  output logic              flag_o,
  output logic [ADDR_W-1:0] gran_o
);

  // Set has priority over any clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      gran_o <= '0;
    end else if (set_i) begin
      flag_o <= 1'b1;
      gran_o <= set_gran_i;
    end else if (clr_i) begin
      flag_o <= 1'b0;
    end
  end

endmodule

// File: rtl/llsc_sc_judge.sv
module llsc_sc_judge
  import llsc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              uncached_i,
  input  logic              flag_i,
  input  logic [ADDR_W-1:0] resv_gran_i,
  input  logic [ADDR_W-1:0] req_gran_i,
  output sc_code_e          code_o,
  output logic              forward_o,
  output logic              nolock_o,
  output logic              mismatch_o,
  output logic              fail_o,
  output logic              pass_o,
  output logic              clear_o
);

  // The no-reservation cause outranks the mismatch cause.
  always_comb begin
    nolock_o   = !uncached_i && !flag_i;
    mismatch_o = !uncached_i && flag_i && (resv_gran_i != req_gran_i);
    fail_o     = nolock_o || mismatch_o;
    pass_o     = !uncached_i && !fail_o;
    forward_o  = !fail_o;
    clear_o    = !uncached_i;
    if (uncached_i)  code_o = SC_BYPASS;
    else if (fail_o) code_o = SC_FAIL;
    else             code_o = SC_PASS;
  end

endmodule

// File: rtl/llsc_fail_ctr.sv
module llsc_fail_ctr #(
  parameter int CNT_W       = 32,
  parameter int WARN_PERIOD = 100000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fail_i,
  input  logic             pass_i,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             warn_nxt_o
);

  localparam int PER_W = (WARN_PERIOD > 2) ? $clog2(WARN_PERIOD) : 1;
  localparam logic [PER_W-1:0] PER_LAST = PER_W'(WARN_PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [PER_W-1:0] per_q, per_nxt;

  function automatic logic at_limit(input logic [CNT_W-1:0] v);
    return &v;
  endfunction

  // A phase counter beside the main count replaces a wide modulo.
  always_comb begin
    cnt_nxt_o  = cnt_q;
    per_nxt    = per_q;
    warn_nxt_o = 1'b0;
    if (pass_i) begin
      cnt_nxt_o = '0;
      per_nxt   = '0;
    end else if (fail_i && !at_limit(cnt_q)) begin
      cnt_nxt_o = cnt_q + 1'b1;
      if (per_q == PER_LAST) begin
        per_nxt    = '0;
        warn_nxt_o = 1'b1;
      end else begin
        per_nxt = per_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      per_q <= '0;
    end else begin
      cnt_q <= cnt_nxt_o;
      per_q <= per_nxt;
    end
  end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NUM_CTX     = 4,
  parameter int ADDR_W      = 32,
  parameter int GRAN_BITS   = 4,
  parameter int CNT_W       = 32,
  parameter int WARN_PERIOD = 100000,
  localparam int CTX_W      = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ll_valid,
  input  logic [CTX_W-1:0]   ll_ctx,
  input  logic [ADDR_W-1:0]  ll_addr,
  input  logic               sc_valid,
  input  logic [CTX_W-1:0]   sc_ctx,
  input  logic [ADDR_W-1:0]  sc_addr,
  input  logic               sc_uncached,
  input  logic [NUM_CTX-1:0] inv_mask,
  output logic               rsp_valid,
  output logic [CTX_W-1:0]   rsp_ctx,
  output logic               rsp_forward,
  output logic [1:0]         rsp_code,
  output logic               rsp_fail_nolock,
  output logic               rsp_fail_mismatch,
  output logic [CNT_W-1:0]   rsp_fail_count,
  output logic               rsp_warn
);

  localparam logic [ADDR_W-1:0] GRAN_MASK = ~((ADDR_W'(1) << GRAN_BITS) - ADDR_W'(1));

  function automatic logic [ADDR_W-1:0] granule(input logic [ADDR_W-1:0] a);
    return a & GRAN_MASK;
  endfunction

  logic [NUM_CTX-1:0]             resv_flag;
  logic [NUM_CTX-1:0][ADDR_W-1:0] resv_gran;
  logic [NUM_CTX-1:0][CNT_W-1:0]  ctx_cnt_nxt;
  logic [NUM_CTX-1:0]             ctx_warn_nxt;

  sc_code_e jd_code;
  logic     jd_forward, jd_nolock, jd_mismatch, jd_fail, jd_pass, jd_clear;

  llsc_sc_judge #(.ADDR_W(ADDR_W)) u_judge (
    .uncached_i  (sc_uncached),
    .flag_i      (resv_flag[sc_ctx]),
    .resv_gran_i (resv_gran[sc_ctx]),
    .req_gran_i  (granule(sc_addr)),
    .code_o      (jd_code),
    .forward_o   (jd_forward),
    .nolock_o    (jd_nolock),
    .mismatch_o  (jd_mismatch),
    .fail_o      (jd_fail),
    .pass_o      (jd_pass),
    .clear_o     (jd_clear)
  );

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    logic ll_hit, sc_hit;
    assign ll_hit = ll_valid && (ll_ctx == CTX_W'(c));
    assign sc_hit = sc_valid && (sc_ctx == CTX_W'(c));

    llsc_resv_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .set_i      (ll_hit),
      .set_gran_i (granule(ll_addr)),
      .clr_i      (inv_mask[c] || (sc_hit && jd_clear)),
      .flag_o     (resv_flag[c]),
      .gran_o     (resv_gran[c])
    );

    llsc_fail_ctr #(.CNT_W(CNT_W), .WARN_PERIOD(WARN_PERIOD)) u_ctr (
      .clk        (clk),
      .rst        (rst),
      .fail_i     (sc_hit && jd_fail),
      .pass_i     (sc_hit && jd_pass),
      .cnt_nxt_o  (ctx_cnt_nxt[c]),
      .warn_nxt_o (ctx_warn_nxt[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid         <= 1'b0;
      rsp_ctx           <= '0;
      rsp_forward       <= 1'b0;
      rsp_code          <= 2'd0;
      rsp_fail_nolock   <= 1'b0;
      rsp_fail_mismatch <= 1'b0;
      rsp_fail_count    <= '0;
      rsp_warn          <= 1'b0;
    end else begin
      rsp_valid         <= sc_valid;
      rsp_ctx           <= sc_ctx;
      rsp_forward       <= sc_valid && jd_forward;
      rsp_code          <= jd_code;
      rsp_fail_nolock   <= sc_valid && jd_nolock;
      rsp_fail_mismatch <= sc_valid && jd_mismatch;
      rsp_fail_count    <= ctx_cnt_nxt[sc_ctx];
      rsp_warn          <= sc_valid && ctx_warn_nxt[sc_ctx];
    end
  end

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int NUM_CTX = 4,
  parameter int CNT_W   = 32,
  parameter int CTX_W   = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               ll_valid,
  input logic [CTX_W-1:0]   ll_ctx,
  input logic               sc_valid,
  input logic [CTX_W-1:0]   sc_ctx,
  input logic               sc_uncached,
  input logic [NUM_CTX-1:0] inv_mask,
  input logic               rsp_valid,
  input logic               rsp_forward,
  input logic [1:0]         rsp_code,
  input logic               rsp_fail_nolock,
  input logic               rsp_fail_mismatch,
  input logic [CNT_W-1:0]   rsp_fail_count,
  input logic               rsp_warn,
  input logic [NUM_CTX-1:0] resv_flag
);

  a_r10_rsp_after_sc: assert property (@(posedge clk) disable iff (rst)
    sc_valid |=> rsp_valid);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !sc_valid |=> !rsp_valid);

  a_r2_nolock: assert property (@(posedge clk) disable iff (rst)
    sc_valid && !sc_uncached && !resv_flag[sc_ctx]
      |=> rsp_code == 2'd0 && rsp_fail_nolock && !rsp_forward);

  a_r3_one_cause: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_fail_nolock, rsp_fail_mismatch}) == ((rsp_code == 2'd0) ? 1 : 0));

  a_r5_pass_resets: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_code == 2'd1 |-> rsp_fail_count == '0 && rsp_forward);

  a_r6_bypass: assert property (@(posedge clk) disable iff (rst)
    sc_valid && sc_uncached |=> rsp_code == 2'd2 && rsp_forward);

  a_r8_warn_on_fail: assert property (@(posedge clk) disable iff (rst)
    rsp_warn |-> rsp_valid && rsp_code == 2'd0);

  a_r1_ll_sets: assert property (@(posedge clk) disable iff (rst)
    ll_valid |=> resv_flag[$past(ll_ctx)]);

  a_r4_sc_clears: assert property (@(posedge clk) disable iff (rst)
    sc_valid && !sc_uncached && !(ll_valid && ll_ctx == sc_ctx)
      |=> !resv_flag[$past(sc_ctx)]);

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_inv
    a_r9_inv_clears: assert property (@(posedge clk) disable iff (rst)
      inv_mask[c] && !(ll_valid && ll_ctx == CTX_W'(c)) |=> !resv_flag[c]);
  end

endmodule

bind llsc_monitor llsc_monitor_chk #(
  .NUM_CTX (NUM_CTX),
  .CNT_W   (CNT_W),
  .CTX_W   (CTX_W)
) u_chk (.*);

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb;

  localparam int NUM_CTX = 2;
  localparam int ADDR_W  = 16;
  localparam int CNT_W   = 4;
  localparam int PERIOD  = 5;
  localparam int LIMIT   = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ll_valid = 1'b0, sc_valid = 1'b0, sc_uncached = 1'b0;
  logic              ll_ctx = 1'b0, sc_ctx = 1'b0;
  logic [ADDR_W-1:0] ll_addr = '0, sc_addr = '0;
  logic [1:0]        inv_mask = '0;
  logic              rsp_valid, rsp_ctx, rsp_forward, rsp_fail_nolock, rsp_fail_mismatch, rsp_warn;
  logic [1:0]        rsp_code;
  logic [CNT_W-1:0]  rsp_fail_count;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  llsc_monitor #(
    .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W), .GRAN_BITS(4), .CNT_W(CNT_W), .WARN_PERIOD(PERIOD)
  ) u_dut (
    .clk(clk), .rst(rst),
    .ll_valid(ll_valid), .ll_ctx(ll_ctx), .ll_addr(ll_addr),
    .sc_valid(sc_valid), .sc_ctx(sc_ctx), .sc_addr(sc_addr), .sc_uncached(sc_uncached),
    .inv_mask(inv_mask),
    .rsp_valid(rsp_valid), .rsp_ctx(rsp_ctx), .rsp_forward(rsp_forward), .rsp_code(rsp_code),
    .rsp_fail_nolock(rsp_fail_nolock), .rsp_fail_mismatch(rsp_fail_mismatch),
    .rsp_fail_count(rsp_fail_count), .rsp_warn(rsp_warn)
  );

  typedef struct packed {
    logic [1:0]  op;     // 0 load-linked, 1 store-conditional, 2 invalidate
    logic        ctx;
    logic [15:0] addr;
    logic        unc;
    logic [1:0]  code;
    logic        fwd;
    logic        nolock;
    logic        mism;
    logic [3:0]  cnt;
    logic        warn;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{2'd1, 1'b0, 16'h1000, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 4'd1, 1'b0}, // R2 after reset
    '{2'd0, 1'b0, 16'h1234, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
    '{2'd1, 1'b0, 16'h123C, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0}, // R1 R5 same granule
    '{2'd1, 1'b0, 16'h1230, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 4'd1, 1'b0}, // R5 flag gone
    '{2'd0, 1'b0, 16'h1234, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
    '{2'd1, 1'b0, 16'h1244, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 4'd2, 1'b0}, // R3
    '{2'd1, 1'b0, 16'h1234, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 4'd3, 1'b0}, // R4
    '{2'd0, 1'b1, 16'h2000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
    '{2'd1, 1'b0, 16'h5555, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 4'd3, 1'b0}, // R6
    '{2'd1, 1'b1, 16'h200F, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0}, // R12
    '{2'd0, 1'b0, 16'h3000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
    '{2'd2, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
    '{2'd1, 1'b0, 16'h3000, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 4'd4, 1'b0}, // R9
    '{2'd1, 1'b0, 16'h3000, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 4'd5, 1'b1}, // R8
    '{2'd0, 1'b1, 16'h4000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
    '{2'd1, 1'b1, 16'h4000, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0}, // R6 keeps flag
    '{2'd1, 1'b1, 16'h4008, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0},
    '{2'd0, 1'b1, 16'h4000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
    '{2'd1, 1'b1, 16'hC000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 4'd1, 1'b0}  // R3 top bit
  };

  // Inputs change at the falling edge; the response is read at the next falling edge.
  task automatic drive(input logic ll, input logic lc, input logic [15:0] la,
                       input logic sc, input logic scc, input logic [15:0] sa,
                       input logic unc, input logic [1:0] inv);
    ll_valid = ll; ll_ctx = lc; ll_addr = la;
    sc_valid = sc; sc_ctx = scc; sc_addr = sa; sc_uncached = unc;
    inv_mask = inv;
    @(negedge clk);
    ll_valid = 1'b0; sc_valid = 1'b0; sc_uncached = 1'b0; inv_mask = '0;
  endtask

  task automatic chk_rsp(input string tag, input logic ctx, input logic [1:0] code,
                         input logic fwd, input logic nl, input logic mm,
                         input logic [3:0] cnt, input logic warn);
    logic [10:0] act, exp;
    act = {rsp_valid, rsp_ctx, rsp_code, rsp_forward, rsp_fail_nolock, rsp_fail_mismatch, rsp_fail_count};
    exp = {1'b1, ctx, code, fwd, nl, mm, cnt};
    act = act ^ {10'd0, 1'b0};
    checks++;
    if (act != exp || rsp_warn != warn) begin
      errors++;
      $display("FAIL %s: got v/ctx/code/fwd/nl/mm/cnt=%b warn=%b, expected %b warn=%b",
               tag, act, rsp_warn, exp, warn);
    end
  endtask

  task automatic chk_idle(input string tag);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL %s: rsp_valid=%b expected 0", tag, rsp_valid);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    chk_idle("R11 reset state");
    rst = 1'b0;
    @(negedge clk);
    chk_idle("R10 idle after reset");

    for (int i = 0; i < NV; i++) begin
      case (TBL[i].op)
        2'd0: drive(1'b1, TBL[i].ctx, TBL[i].addr, 1'b0, 1'b0, '0, 1'b0, 2'b00);
        2'd2: drive(1'b0, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 2'b01 << TBL[i].ctx);
        default: begin
          drive(1'b0, 1'b0, '0, 1'b1, TBL[i].ctx, TBL[i].addr, TBL[i].unc, 2'b00);
          chk_rsp($sformatf("table row %0d", i), TBL[i].ctx, TBL[i].code, TBL[i].fwd,
                  TBL[i].nolock, TBL[i].mism, TBL[i].cnt, TBL[i].warn);
        end
      endcase
    end

    // R7 R8: climb context 0 from 5 to the limit and one step past it
    c = 5;
    for (int k = 0; k < 11; k++) begin
      logic w;
      w = (c < LIMIT) && (((c + 1) % PERIOD) == 0);
      if (c < LIMIT) c = c + 1;
      drive(1'b0, 1'b0, '0, 1'b1, 1'b0, 16'h3000, 1'b0, 2'b00);
      chk_rsp("R7 R8 saturating count", 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 4'(c), w);
    end

    // R5: pass clears a saturated count
    drive(1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, '0, 1'b0, 2'b00);
    drive(1'b0, 1'b0, '0, 1'b1, 1'b0, 16'h000F, 1'b0, 2'b00);
    chk_rsp("R5 pass resets count", 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0);

    // R9: load-linked beats invalidate in the same cycle
    drive(1'b1, 1'b1, 16'h7000, 1'b0, 1'b0, '0, 1'b0, 2'b10);
    drive(1'b0, 1'b0, '0, 1'b1, 1'b1, 16'h7004, 1'b0, 2'b00);
    chk_rsp("R9 load-linked wins", 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0);

    // R12: invalidate of context 0 leaves context 1
    drive(1'b1, 1'b1, 16'h8000, 1'b0, 1'b0, '0, 1'b0, 2'b00);
    drive(1'b0, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 2'b01);
    drive(1'b0, 1'b0, '0, 1'b1, 1'b1, 16'h8000, 1'b0, 2'b00);
    chk_rsp("R12 other context untouched", 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0);

    // R1: same-cycle load-linked and store-conditional
    drive(1'b1, 1'b0, 16'h6000, 1'b1, 1'b0, 16'h6000, 1'b0, 2'b00);
    chk_rsp("R1 sc sees old flag", 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 4'd1, 1'b0);
    drive(1'b0, 1'b0, '0, 1'b1, 1'b0, 16'h6000, 1'b0, 2'b00);
    chk_rsp("R1 flag set after", 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0);

    @(negedge clk);
    chk_idle("R10 no response without request");

    // R11: mid-run reset
    drive(1'b1, 1'b1, 16'h9000, 1'b0, 1'b0, '0, 1'b0, 2'b00);
    drive(1'b0, 1'b0, '0, 1'b1, 1'b0, 16'h1111, 1'b0, 2'b00);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk_idle("R11 reset drops response");
    rst = 1'b0;
    drive(1'b0, 1'b0, '0, 1'b1, 1'b1, 16'h9000, 1'b0, 2'b00);
    chk_rsp("R11 flag cleared", 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 4'd1, 1'b0);
    drive(1'b0, 1'b0, '0, 1'b1, 1'b0, 16'h1111, 1'b0, 2'b00);
    chk_rsp("R11 count cleared", 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 4'd1, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule